// File: doc/BRIEF.md
# Audio FIFO Threshold Interrupt Controller

This block turns the fill levels of an audio port's transmit and receive FIFOs into a single interrupt request. It compares those levels with two programmable watermarks. It latches underrun and overrun events in sticky flags. It gates each condition with its own enable and merges the result into one registered interrupt line. Software reaches the block through a simple word-wide register port: a write strobe with address and data, and a combinational read-data bus.

The transmit side has four channel groups, and each group reports its own 6-bit level. The transmit watermark is compared with the emptiest group, because that group runs dry first. Both watermarks are stored as the threshold value minus one, so a field value of 0 means a threshold of 1. The FIFO storage sits outside this block; only its levels and event pulses come in.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the interrupt-control word at offset 0x14 reads 0, the sticky flags are clear and `irq_o` is 0.
- R2: Offset 0x14 stores the receive watermark in bits 24:20, the overrun enable in bit 17, the receive-watermark enable in bit 16, the transmit watermark in bits 8:4, the underrun enable in bit 1 and the transmit-watermark enable in bit 0. Every other bit, including the clear strobes at bits 18 and 2, reads back 0.
- R3: Status bit 0 (offset 0x18) is 1 exactly while the smallest of the four transmit group levels is less than or equal to the transmit field plus one.
- R4: Status bit 16 is 1 exactly while the receive level is greater than the receive field plus one.
- R5: Status bit 1 (underrun) becomes 1 on the clock edge that samples `tx_undr_i` high, and it stays 1 until it is cleared.
- R6: Status bit 17 (overrun) becomes 1 on the clock edge that samples `rx_ovr_i` high, and it stays 1 until it is cleared.
- R7: A write to 0x14 with bit 2 set clears the underrun flag, and a write with bit 18 set clears the overrun flag. A clear strobe affects only its own flag, and a write with the strobe at 0 clears nothing.
- R8: When an event pulse and its clear strobe arrive in the same cycle, the flag ends up set.
- R9: Offset 0x0C reads the receive level in bits 29:24 and transmit groups 3, 2, 1 and 0 in bits 23:18, 17:12, 11:6 and 5:0. Bits 31:30 read 0.
- R10: `irq_o` is the OR of the four status bits, each ANDed with its enable bit. It comes from a register, so it follows the status and enables one clock edge later.
- R11: Writes to offsets 0x0C and 0x18, or to any unmapped offset, change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_lvl_i | input | 24 | Transmit group levels, 6 bits each, group 0 in the low bits |
| rx_lvl_i | input | 6 | Receive FIFO level |
| tx_undr_i | input | 1 | Transmit underrun event pulse |
| rx_ovr_i | input | 1 | Receive overrun event pulse |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to set up is an event pulse that lands in the same cycle as the write that clears its flag. The bench gets there by raising the pulse and the write strobe at the same falling edge, so that a single rising edge samples both. The watermark compare is swept over every field value and every level. In that sweep the minimum moves among the transmit groups, so each group in turn is the one the compare uses, and both sides of each watermark boundary are covered.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int LVL_W    = 6;
    localparam int THR_W    = 5;
    localparam int TX_GRPS  = 4;
    localparam int TX_LVL_W = LVL_W * TX_GRPS;
    localparam int AW       = 8;
    localparam int DW       = 32;
    localparam int N_STICKY = 2;

    localparam logic [AW-1:0] OFS_LEVEL = 8'h0C;
    localparam logic [AW-1:0] OFS_CTRL  = 8'h14;
    localparam logic [AW-1:0] OFS_STAT  = 8'h18;

    // bit positions shared by control, status and enable vectors
    localparam int B_TXE     = 0;
    localparam int B_UND     = 1;
    localparam int B_UND_CLR = 2;
    localparam int B_TXTHR   = 4;
    localparam int B_RXF     = 16;
    localparam int B_OVR     = 17;
    localparam int B_OVR_CLR = 18;
    localparam int B_RXTHR   = 20;

    typedef struct packed {
        logic [THR_W-1:0] rx_thr;
        logic             ovr_en;
        logic             rxf_en;
        logic [THR_W-1:0] tx_thr;
        logic             und_en;
        logic             txe_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
        ctrl_t c;
        c.rx_thr = w[B_RXTHR +: THR_W];
        c.ovr_en = w[B_OVR];
        c.rxf_en = w[B_RXF];
        c.tx_thr = w[B_TXTHR +: THR_W];
        c.und_en = w[B_UND];
        c.txe_en = w[B_TXE];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[B_RXTHR +: THR_W] = c.rx_thr;
        w[B_OVR]            = c.ovr_en;
        w[B_RXF]            = c.rxf_en;
        w[B_TXTHR +: THR_W] = c.tx_thr;
        w[B_UND]            = c.und_en;
        w[B_TXE]            = c.txe_en;
        return w;
    endfunction

endpackage

// File: rtl/fifo_irq_thr_cmp.sv
module fifo_irq_thr_cmp
    import fifo_irq_pkg::*;
#(
    parameter int LW   = LVL_W,
    parameter int TW   = THR_W,
    parameter int GRPS = TX_GRPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW*GRPS-1:0] tx_lvl_i,
    input  logic [LW-1:0]    rx_lvl_i,
    input  logic [TW-1:0]    tx_thr_i,
    input  logic [TW-1:0]    rx_thr_i,
    output logic             tx_hit_o,
    output logic             rx_hit_o
);

    logic [LW-1:0] run_min [GRPS];
    logic [LW-1:0] tx_lim;
    logic [LW-1:0] rx_lim;

    assign run_min[0] = tx_lvl_i[0 +: LW];

    generate
        for (genvar g = 1; g < GRPS; g++) begin : g_min
            assign run_min[g] = (tx_lvl_i[g*LW +: LW] < run_min[g-1]) ?
                                tx_lvl_i[g*LW +: LW] : run_min[g-1];
        end
    endgenerate

    // fields hold threshold minus one
    assign tx_lim = LW'(tx_thr_i) + LW'(1);
    assign rx_lim = LW'(rx_thr_i) + LW'(1);

    assign tx_hit_o = (run_min[GRPS-1] <= tx_lim);
    assign rx_hit_o = (rx_lvl_i > rx_lim);

    generate
        for (genvar g = 0; g < GRPS; g++) begin : g_chk
            // R3: the selected level never exceeds any group's level
            assert_min_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
                run_min[GRPS-1] <= tx_lvl_i[g*LW +: LW]);
        end
    endgenerate

    // R4: a receive hit implies the level is strictly above the raw field
    assert_rx_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit_o |-> (rx_lvl_i > LW'(rx_thr_i)));

endmodule

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // event outranks clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R5 and R6: a flag without a clear stays up
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    // R8: an event always leaves the flag set
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R7: a clear with no event drops the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TX_LVL_W-1:0] tx_lvl_i,
    input  logic [LVL_W-1:0]    rx_lvl_i,
    input  logic                tx_undr_i,
    input  logic                rx_ovr_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    output logic                irq_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  irq;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic                ctrl_wr;
    logic                tx_hit;
    logic                rx_hit;
    logic [N_STICKY-1:0] evt_set;
    logic [N_STICKY-1:0] evt_clr;
    logic [N_STICKY-1:0] evt_flag;
    logic [DW-1:0]       stat_w;
    logic [DW-1:0]       en_w;
    logic [DW-1:0]       lvl_w;

    assign ctrl_wr = reg_wr_i && (reg_addr_i == OFS_CTRL);

    fifo_irq_thr_cmp u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_lvl_i (tx_lvl_i),
        .rx_lvl_i (rx_lvl_i),
        .tx_thr_i (st_q.ctrl.tx_thr),
        .rx_thr_i (st_q.ctrl.rx_thr),
        .tx_hit_o (tx_hit),
        .rx_hit_o (rx_hit)
    );

    // index 0: transmit underrun, index 1: receive overrun
    assign evt_set[0] = tx_undr_i;
    assign evt_clr[0] = ctrl_wr && reg_wdata_i[B_UND_CLR];
    assign evt_set[1] = rx_ovr_i;
    assign evt_clr[1] = ctrl_wr && reg_wdata_i[B_OVR_CLR];

    generate
        for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
            fifo_irq_sticky u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt_set[k]),
                .clr_i  (evt_clr[k]),
                .flag_o (evt_flag[k])
            );
        end
    endgenerate

    always_comb begin
        stat_w        = '0;
        stat_w[B_TXE] = tx_hit;
        stat_w[B_UND] = evt_flag[0];
        stat_w[B_RXF] = rx_hit;
        stat_w[B_OVR] = evt_flag[1];

        en_w          = '0;
        en_w[B_TXE]   = st_q.ctrl.txe_en;
        en_w[B_UND]   = st_q.ctrl.und_en;
        en_w[B_RXF]   = st_q.ctrl.rxf_en;
        en_w[B_OVR]   = st_q.ctrl.ovr_en;

        lvl_w         = DW'({rx_lvl_i, tx_lvl_i});
    end

    always_comb begin
        st_d     = st_q;
        if (ctrl_wr) st_d.ctrl = ctrl_from_word(reg_wdata_i);
        st_d.irq = |(stat_w & en_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_i)
            OFS_LEVEL: reg_rdata_o = lvl_w;
            OFS_CTRL:  reg_rdata_o = ctrl_to_word(st_q.ctrl);
            OFS_STAT:  reg_rdata_o = stat_w;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    // R10: an enabled condition raises the line one edge later
    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_w & en_w) != '0) |=> irq_o);

    // R10: with nothing enabled and active, the line is low one edge later
    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_w & en_w) == '0) |=> !irq_o);

endmodule

// File: tb/fifo_irq_ctrl_tb.sv
module fifo_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] tx_lvl = '1;
    logic [5:0]  rx_lvl = '0;
    logic        tx_undr = 1'b0;
    logic        rx_ovr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_vec = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fifo_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_lvl_i    (tx_lvl),
        .rx_lvl_i    (rx_lvl),
        .tx_undr_i   (tx_undr),
        .rx_ovr_i    (rx_ovr),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input bit ovr);
        @(negedge clk);
        if (ovr) rx_ovr = 1'b1; else tx_undr = 1'b1;
        @(negedge clk);
        rx_ovr = 1'b0; tx_undr = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h14, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h18, d); chk("R1 status", d & 32'h0002_0002, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2: readback with all ones, then zeros
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); chk("R2 ones", d, 32'h01F3_01F3);
        wr(8'h14, 32'h0);
        rd(8'h14, d); chk("R2 zeros", d, 32'h0);
        wr(8'h14, 32'h00A3_0042);
        rd(8'h14, d); chk("R2 pattern", d, 32'h00A3_0042);
        wr(8'h14, 32'h0);

        // R3, R4, R9: sweep every field value and every level
        for (int thr = 0; thr < 32; thr++) begin
            wr(8'h14, (32'(thr) << 20) | (32'(thr) << 4));
            for (int lv = 0; lv < 64; lv++) begin
                logic [23:0] t;
                int mn;
                int sel;
                sel = lv % 4;
                mn = 63;
                for (int g = 0; g < 4; g++) begin
                    int v;
                    v = (g == sel) ? lv : (63 - ((lv + 7 * g) % 16));
                    t[g*6 +: 6] = 6'(v);
                    if (v < mn) mn = v;
                end
                @(negedge clk);
                tx_lvl = t; rx_lvl = 6'(lv);
                reg_addr = 8'h18;
                #1 d = reg_rdata;
                chk("R3 tx watermark", {31'b0, d[0]}, {31'b0, (mn <= thr + 1)});
                chk("R4 rx watermark", {31'b0, d[16]}, {31'b0, (lv > thr + 1)});
                if (thr == 5) begin
                    rd(8'h0C, d);
                    chk("R9 level word", d, {2'b00, 6'(lv), t});
                end
            end
        end

        // neutral levels: no watermark hits with field 0
        @(negedge clk); tx_lvl = '1; rx_lvl = '0;
        wr(8'h14, 32'h0);

        // R5: underrun sets and holds
        pulse(1'b0);
        rd(8'h18, d); chk("R5 underrun set", d, 32'h0000_0002);
        repeat (5) @(negedge clk);
        rd(8'h18, d); chk("R5 underrun hold", d, 32'h0000_0002);

        // R6: overrun sets and holds
        pulse(1'b1);
        rd(8'h18, d); chk("R6 overrun set", d, 32'h0002_0002);
        repeat (5) @(negedge clk);
        rd(8'h18, d); chk("R6 overrun hold", d, 32'h0002_0002);

        // R11: writes elsewhere change nothing
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h14, d); chk("R11 ctrl unchanged", d, 32'h0);
        rd(8'h18, d); chk("R11 flags unchanged", d, 32'h0002_0002);
        rd(8'h00, d); chk("R11 unmapped read 0x00", d, 32'h0);
        rd(8'h10, d); chk("R11 unmapped read 0x10", d, 32'h0);

        // R7: strobe at zero clears nothing, then each strobe alone
        wr(8'h14, 32'h0003_0003);
        rd(8'h18, d); chk("R7 no strobe", d, 32'h0002_0002);
        wr(8'h14, 32'h0000_0004);
        rd(8'h18, d); chk("R7 underrun cleared only", d, 32'h0002_0000);
        wr(8'h14, 32'h0004_0000);
        rd(8'h18, d); chk("R7 overrun cleared", d, 32'h0);
        rd(8'h14, d); chk("R7 strobes not stored", d, 32'h0);

        // R8: event and clear in one cycle
        @(negedge clk);
        reg_addr = 8'h14; reg_wdata = 32'h0004_0004; reg_wr = 1'b1;
        tx_undr = 1'b1; rx_ovr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_undr = 1'b0; rx_ovr = 1'b0;
        rd(8'h18, d); chk("R8 set wins", d, 32'h0002_0002);
        wr(8'h14, 32'h0004_0004);
        rd(8'h18, d); chk("R8 cleared after", d, 32'h0);

        // R10: masked condition keeps the line low
        @(negedge clk); rx_lvl = 6'd10;
        repeat (2) @(negedge clk);
        chk("R10 masked", {31'b0, irq}, 32'h0);
        @(negedge clk); rx_lvl = 6'd0;

        // R10: receive watermark latency
        wr(8'h14, 32'h0001_0000);
        @(negedge clk); chk("R10 idle", {31'b0, irq}, 32'h0);
        rx_lvl = 6'd2;
        #1 chk("R10 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk); chk("R10 rx raise", {31'b0, irq}, 32'h1);
        rx_lvl = 6'd1;
        @(negedge clk); chk("R10 rx drop", {31'b0, irq}, 32'h0);

        // R10: transmit watermark source
        wr(8'h14, 32'h0000_0001);
        @(negedge clk); tx_lvl[12 +: 6] = 6'd0;
        @(negedge clk); chk("R10 tx raise", {31'b0, irq}, 32'h1);
        tx_lvl = '1;
        @(negedge clk); chk("R10 tx drop", {31'b0, irq}, 32'h0);

        // R10: underrun source, cleared by strobe
        wr(8'h14, 32'h0000_0002);
        pulse(1'b0);
        @(negedge clk); chk("R10 underrun raise", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h0000_0006);
        @(negedge clk); chk("R10 underrun drop", {31'b0, irq}, 32'h0);

        // R10: overrun source
        wr(8'h14, 32'h0002_0000);
        pulse(1'b1);
        @(negedge clk); chk("R10 overrun raise", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h0006_0000);
        @(negedge clk); chk("R10 overrun drop", {31'b0, irq}, 32'h0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule